// File: doc/BRIEF.md
# Vector shift-and-insert scalar unit

This unit decodes and executes a single vector instruction: it moves a wide vector register up by one element and writes a scalar value into the freed lowest element. It holds its own file of 32 vector registers, each `VL` bits wide (256 by default). The scalar operand comes from an external 64-bit general-purpose register file. The unit drives the register index and takes back the data in the same cycle.

A 32-bit instruction word is offered with a valid strobe. When the word carries the fixed opcode pattern, the element width is taken from a 2-bit size field. The named vector register is then shifted up by that width, and the low bits of the scalar fill the bottom element. The result is committed exactly one cycle after acceptance, and a done pulse marks the commit. Words that do not carry the pattern raise a one-cycle undefined flag and change nothing. A debug read port lets any vector register be observed. Latency never depends on operand values. A word issued directly behind another that targets the same register sees the earlier result through a bypass.

Top module: `vsi_insert_unit`

## Requirements
- R1: After reset every vector register reads zero on the debug port, and `done` and `undef` are low.
- R2: A word with bits 31:24 = 8'h05 and bits 21:10 = 12'h90E, offered with `instr_valid`, gives `done` high and `undef` low in the cycle after the accepting edge.
- R3: A valid word that breaks either fixed field gives `undef` high and `done` low in the following cycle, and leaves every vector register unchanged.
- R4: The element width is 8 << size, where size is bits 23:22 (0 gives 8, 1 gives 16, 2 gives 32, 3 gives 64).
- R5: The new value of the target register is the old value's low VL−esize bits placed at bit esize upward, with the scalar's low esize bits in bits esize−1:0.
- R6: `gpr_idx` equals bits 9:5 of the offered word in the same cycle. Bits 4:0 name the vector register that is both read and written.
- R7: A scalar index of 31 inserts zero, whatever `gpr_data` carries.
- R8: Bits of `gpr_data` above esize have no effect on the result.
- R9: Latency is fixed at one cycle regardless of data. Words issued on consecutive cycles to the same register each build on the previous result.
- R10: `dbg_data` shows register `dbg_idx` combinationally, and changes only after a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction word is offered this cycle |
| instr_word | input | 32 | Instruction word |
| gpr_idx | output | 5 | Scalar register index, from bits 9:5 |
| gpr_data | input | 64 | Scalar register value for `gpr_idx`, same cycle |
| done | output | 1 | One-cycle pulse with the write-back of an accepted word |
| undef | output | 1 | One-cycle pulse after a word that failed decode |
| dbg_idx | input | 5 | Debug read register index |
| dbg_data | output | VL | Debug read data |

## Verification
A wrong element-size decode or a wrong shift shows up on `dbg_data` as a misplaced or truncated element one cycle after `done`. The error then spreads to every later insert into that register, so a full register sweep after each burst exposes it. A stale bypass shows only when words to the same register arrive on back-to-back cycles, and the sweep that follows such a burst catches it. A decode fault shows at once on `done` or `undef` in the cycle after the offending word, and as an unexpected register change in the next sweep.

// File: rtl/vsi_pkg.sv
package vsi_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned IDX_W   = 5;
  localparam int unsigned NREG    = 1 << IDX_W;
  localparam int unsigned SCAL_W  = 64;

  // fixed opcode fields
  localparam logic [7:0]  OPC_TOP = 8'h05;
  localparam logic [11:0] OPC_MID = 12'h90E;

  localparam logic [IDX_W-1:0] ZERO_REG = '1;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'd0,
    ESZ_H16 = 2'd1,
    ESZ_S32 = 2'd2,
    ESZ_D64 = 2'd3
  } esz_e;

  typedef struct packed {
    logic             hit;
    esz_e             esz;
    logic [IDX_W-1:0] src;
    logic [IDX_W-1:0] dst;
  } dec_t;

  function automatic logic word_is_insert(input logic [WORD_W-1:0] w);
    return (w[31:24] == OPC_TOP) && (w[21:10] == OPC_MID);
  endfunction

endpackage

// File: rtl/vsi_rst_sync.sv
module vsi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/vsi_decode.sv
module vsi_decode
  import vsi_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output dec_t              dec
);

  logic top_ok;
  logic mid_ok;

  always_comb begin
    top_ok   = (word[31:24] == OPC_TOP);
    mid_ok   = (word[21:10] == OPC_MID);
    dec.hit  = top_ok & mid_ok;
    dec.esz  = esz_e'(word[23:22]);
    dec.src  = word[9:5];
    dec.dst  = word[4:0];
  end

endmodule

// File: rtl/vsi_shifter.sv
module vsi_shifter
  import vsi_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic [VL-1:0]     old_vec,
  input  logic [SCAL_W-1:0] scalar,
  input  esz_e              esz,
  output logic [VL-1:0]     new_vec
);

  localparam int unsigned NSZ = 4;

  logic [VL-1:0] cand [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int unsigned EW = 8 << s;
    assign cand[s] = {old_vec[VL-EW-1:0], scalar[EW-1:0]};
  end

  always_comb new_vec = cand[esz];

endmodule

// File: rtl/vsi_vregfile.sv
module vsi_vregfile
  import vsi_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VL-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [VL-1:0]    rd_a_data,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [VL-1:0]    rd_b_data
);

  logic [VL-1:0] ent [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic          en;
    logic [VL-1:0] q;

    always_comb en = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= wr_data;
    end

    assign ent[i] = q;
  end

  always_comb begin
    rd_a_data = ent[rd_a_idx];
    rd_b_data = ent[rd_b_idx];
  end

endmodule

// File: rtl/vsi_insert_unit.sv
module vsi_insert_unit
  import vsi_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [WORD_W-1:0] instr_word,
  output logic [IDX_W-1:0]  gpr_idx,
  input  logic [SCAL_W-1:0] gpr_data,
  output logic              done,
  output logic              undef,
  input  logic [IDX_W-1:0]  dbg_idx,
  output logic [VL-1:0]     dbg_data
);

  logic rst_n_s;

  vsi_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  dec_t dec;

  vsi_decode u_dec (
    .word (instr_word),
    .dec  (dec)
  );

  assign gpr_idx = dec.src;

  // write-back stage
  logic             wb_vld_q, wb_vld_d;
  logic [IDX_W-1:0] wb_idx_q, wb_idx_d;
  logic [VL-1:0]    wb_dat_q, wb_dat_d;
  logic             undef_q, undef_d;

  logic [VL-1:0]     rf_rd;
  logic [VL-1:0]     op_vec;
  logic [SCAL_W-1:0] scalar;
  logic [VL-1:0]     res_vec;
  logic              accept;
  logic              reject;
  logic              fwd;

  vsi_vregfile #(.VL(VL)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wb_vld_q),
    .wr_idx    (wb_idx_q),
    .wr_data   (wb_dat_q),
    .rd_a_idx  (dec.dst),
    .rd_a_data (rf_rd),
    .rd_b_idx  (dbg_idx),
    .rd_b_data (dbg_data)
  );

  always_comb begin
    fwd    = wb_vld_q && (wb_idx_q == dec.dst);
    op_vec = fwd ? wb_dat_q : rf_rd;
    scalar = (dec.src == ZERO_REG) ? '0 : gpr_data;
  end

  vsi_shifter #(.VL(VL)) u_shf (
    .old_vec (op_vec),
    .scalar  (scalar),
    .esz     (dec.esz),
    .new_vec (res_vec)
  );

  always_comb begin
    accept   = instr_valid && dec.hit;
    reject   = instr_valid && !dec.hit;
    wb_vld_d = accept;
    undef_d  = reject;
    wb_idx_d = wb_idx_q;
    wb_dat_d = wb_dat_q;
    if (accept) begin
      wb_idx_d = dec.dst;
      wb_dat_d = res_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wb_vld_q <= 1'b0;
      undef_q  <= 1'b0;
      wb_idx_q <= '0;
      wb_dat_q <= '0;
    end else begin
      wb_vld_q <= wb_vld_d;
      undef_q  <= undef_d;
      wb_idx_q <= wb_idx_d;
      wb_dat_q <= wb_dat_d;
    end
  end

  assign done  = wb_vld_q;
  assign undef = undef_q;

endmodule

// File: rtl/vsi_insert_chk.sv
module vsi_insert_chk
  import vsi_pkg::*;
#(
  parameter int unsigned VL = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              instr_valid,
  input logic [WORD_W-1:0] instr_word,
  input logic              done,
  input logic              undef,
  input logic [IDX_W-1:0]  dbg_idx,
  input logic [VL-1:0]     dbg_data
);

  // R2
  hit_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && word_is_insert(instr_word)) |=> (done && !undef));

  // R3
  miss_gives_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !word_is_insert(instr_word)) |=> (undef && !done));

  // R3
  undef_excl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && undef));

  // R9
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> (!done && !undef));

  // R10
  dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(dbg_idx) && !$past(done)) |-> $stable(dbg_data));

endmodule

bind vsi_insert_unit vsi_insert_chk #(.VL(VL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .done        (done),
  .undef       (undef),
  .dbg_idx     (dbg_idx),
  .dbg_data    (dbg_data)
);

// File: tb/vsi_insert_unit_test.sv
`timescale 1ns/1ps
module vsi_insert_unit_test;

  localparam int VL = 256;
  localparam int NR = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_valid;
  logic [31:0]   instr_word;
  logic [4:0]    gpr_idx;
  logic [63:0]   gpr_data;
  logic          done;
  logic          undef;
  logic [4:0]    dbg_idx;
  logic [VL-1:0] dbg_data;

  always #4 clk = ~clk;

  logic [63:0]   gfile [NR];
  logic [VL-1:0] model [NR];

  assign gpr_data = gfile[gpr_idx];

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  vsi_insert_unit #(.VL(VL)) uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .gpr_idx(gpr_idx), .gpr_data(gpr_data), .done(done), .undef(undef),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  task automatic chk(input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] sz, input logic [4:0] rm, input logic [4:0] zd);
    return {8'h05, sz, 12'h90E, rm, zd};
  endfunction

  function automatic bit is_ins(input logic [31:0] w);
    return (((w >> 24) & 32'hFF) == 32'h05) && (((w >> 10) & 32'hFFF) == 32'h90E);
  endfunction

  function automatic logic [VL-1:0] apply(input logic [VL-1:0] old, input logic [63:0] s, input logic [1:0] sz);
    int esz;
    logic [63:0] m;
    esz = 8 << sz;
    m = (esz == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << esz) - 64'd1);
    return (old << esz) | VL'(s & m);
  endfunction

  task automatic exec_model(input logic [31:0] w);
    logic [63:0] s;
    if (is_ins(w)) begin
      s = (w[9:5] == 5'd31) ? 64'd0 : gfile[w[9:5]];
      model[w[4:0]] = apply(model[w[4:0]], s, w[23:22]);
    end
  endtask

  task automatic check_flags(input logic [31:0] w, input string tag);
    chk({tag, " R2 done"}, VL'(done), VL'(is_ins(w)));
    chk({tag, " R3 undef"}, VL'(undef), VL'(!is_ins(w)));
  endtask

  task automatic issue(input logic [31:0] w, input string tag);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    #0.5;
    chk({tag, " R6 gpr_idx"}, VL'(gpr_idx), VL'(w[9:5]));
    @(negedge clk);
    instr_valid = 1'b0;
    check_flags(w, tag);
    exec_model(w);
  endtask

  task automatic check_reg(input int idx, input string tag);
    @(negedge clk);
    @(negedge clk);
    dbg_idx = 5'(idx);
    #0.5;
    chk({tag, " R10 reg"}, dbg_data, model[idx]);
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < NR; i++) begin
      dbg_idx = 5'(i);
      #0.1;
      chk({tag, " R10 sweep"}, dbg_data, model[i]);
    end
  endtask

  task automatic stream(input logic [31:0] ws [8], input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        check_flags(ws[k-1], tag);
        exec_model(ws[k-1]);
      end
      instr_valid = 1'b1;
      instr_word  = ws[k];
    end
    @(negedge clk);
    instr_valid = 1'b0;
    check_flags(ws[n-1], tag);
    exec_model(ws[n-1]);
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    int bp;
    w = mk(2'($urandom % 4), 5'($urandom % 32), 5'($urandom % 32));
    if (($urandom % 6) == 0) begin
      bp = int'($urandom % 20);
      bp = (bp < 12) ? bp + 10 : bp + 4;
      w = w ^ (32'd1 << bp);
    end
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ws [8];
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NR; i++) begin
      gfile[i] = {$urandom, $urandom};
      model[i] = '0;
    end
    gfile[31] = 64'hFFFF_FFFF_FFFF_FFFF;
    gfile[1]  = 64'h0123_4567_89AB_CDEF;
    rst_n = 1'b0;
    instr_valid = 1'b0;
    instr_word = '0;
    dbg_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 done", VL'(done), '0);
    chk("R1 undef", VL'(undef), '0);
    check_all("R1");

    // R4 R5 each size into reg 3, explicit expected value
    issue(mk(2'd0, 5'd1, 5'd3), "R4 b8");
    check_reg(3, "R5 b8");
    chk("R5 b8 literal", model[3], VL'(64'hEF));
    issue(mk(2'd1, 5'd1, 5'd3), "R4 h16");
    issue(mk(2'd2, 5'd1, 5'd3), "R4 s32");
    issue(mk(2'd3, 5'd1, 5'd3), "R4 d64");
    check_reg(3, "R5 d64");
    @(negedge clk);
    dbg_idx = 5'd3;
    #0.5;
    chk("R5 literal", dbg_data, VL'(128'h00EF_CDEF_89AB_CDEF_0123_4567_89AB_CDEF));

    // R7 zero register, its data lines all ones
    issue(mk(2'd3, 5'd31, 5'd3), "R7 zr");
    check_reg(3, "R7 zr");
    @(negedge clk);
    #0.5;
    chk("R7 low zero", VL'(dbg_data[63:0]), '0);

    // R8 upper scalar bits ignored
    gfile[2] = 64'hA5A5_A5A5_A5A5_A55A;
    issue(mk(2'd0, 5'd2, 5'd7), "R8");
    check_reg(7, "R8");
    @(negedge clk);
    dbg_idx = 5'd7;
    #0.5;
    chk("R8 literal", dbg_data, VL'(8'h5A));

    // R3 corrupted opcode fields
    issue(mk(2'd0, 5'd1, 5'd3) ^ 32'h0100_0000, "R3 top");
    issue(mk(2'd2, 5'd1, 5'd3) ^ 32'h0000_0400, "R3 mid");
    issue(32'h0000_0000, "R3 zero");
    check_all("R3 unchanged");

    // R9 back-to-back to one register, bypass path
    ws[0] = mk(2'd0, 5'd4, 5'd9);
    ws[1] = mk(2'd1, 5'd5, 5'd9);
    ws[2] = mk(2'd2, 5'd6, 5'd9);
    ws[3] = mk(2'd0, 5'd1, 5'd9) ^ 32'h0020_0000;
    ws[4] = mk(2'd3, 5'd8, 5'd9);
    ws[5] = mk(2'd0, 5'd31, 5'd9);
    ws[6] = mk(2'd1, 5'd4, 5'd10);
    ws[7] = mk(2'd0, 5'd6, 5'd9);
    stream(ws, 8, "R9 burst");
    check_all("R9 burst");

    // random mix
    for (int it = 0; it < 40; it++) begin
      for (int j = 0; j < 6; j++) issue(rand_word(), "R5 rand");
      for (int j = 0; j < 8; j++) ws[j] = rand_word();
      stream(ws, 8, "R9 rand");
      if ((it % 8) == 7) check_all("R5 rand");
    end
    check_all("R10 final");

    ended = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule